// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the low address bits of a four-beat memory burst. When a new access begins, the controller pulses `load` and the block captures the full starting address. From then on, every clock edge with a qualified advance moves the burst one beat forward. The low bits follow one of two wrap orders, chosen by the static `order_sel` input. The upper address bits stay at their captured value for the whole burst.

Interleaved order combines the starting low bits with the beat count by bitwise exclusive-OR. Linear order adds the beat count to the starting low bits modulo four. An edge without a qualified advance suspends the burst, and the address stays where it is. The controller decodes the strobes and the access type. Only the two strobe levels and the active-low advance reach this block, and together they decide whether it steps.

Top module: `burst_addr_ctr`

## Requirements
- R1: After reset, `burst_addr` is all zeros and `beat_idx` is 0.
- R2: An edge with `load` high captures `start_addr`. After that edge, `burst_addr` equals `start_addr` and `beat_idx` is 0.
- R3: With `order_sel` = 1 (interleaved), the low two bits of `burst_addr` equal the starting low bits XOR `beat_idx`. A start of 01 gives 01, 00, 11, 10.
- R4: With `order_sel` = 0 (linear), the low two bits equal the starting low bits plus `beat_idx`, modulo 4. A start of 01 gives 01, 10, 11, 00.
- R5: An edge with `load` low, `adv_n` low and both `strb_a_n` and `strb_b_n` high increments `beat_idx` by one, modulo 4.
- R6: An edge with `load` low and any of these conditions leaves `burst_addr` and `beat_idx` unchanged: `adv_n` high, `strb_a_n` low, or `strb_b_n` low.
- R7: `load` has priority over advance. A load edge with a qualified advance still gives `beat_idx` = 0 and the new start address.
- R8: A step from beat 3 wraps to beat 0 and returns the low bits to the starting value. No end-of-burst condition stops the counter.
- R9: Bits `[ADDR_W-1:2]` of `burst_addr` keep the value captured at load throughout the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| order_sel | input | 1 | Static wrap order: 1 selects interleaved, 0 selects linear |
| load | input | 1 | Starts a new burst at `start_addr` |
| start_addr | input | ADDR_W | Starting address of the burst |
| adv_n | input | 1 | Advance request, active low |
| strb_a_n | input | 1 | First address strobe level, active low |
| strb_b_n | input | 1 | Second address strobe level, active low |
| burst_addr | output | ADDR_W | Current burst address |
| beat_idx | output | 2 | Current beat number, 0 to 3 |

## Verification
A new load and a qualified advance can arrive on the same edge. A burst can also reach the wrap point on the same edge that a new load arrives. The bench provokes the first case by raising `load` together with `adv_n` low and both strobes high in the middle of a burst. It judges the result by requiring beat 0 and the new start address after that edge. It also checks the suspend qualifiers one at a time on the edge before a step, so that each qualifier alone must hold the address.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_step_qual.sv
module burst_step_qual (
  input  logic load,
  input  logic adv_n,
  input  logic strb_a_n,
  input  logic strb_b_n,
  output logic load_ev,
  output logic step_ev
);
  // load wins; a step needs advance low and both strobes idle (R5, R7)
  assign load_ev = load;
  assign step_ev = !load && !adv_n && strb_a_n && strb_b_n;
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int ADDR_W = 17,
  parameter int LOW_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ev,
  input  logic              step_ev,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [LOW_W-1:0]  base_low,
  output logic [ADDR_W-LOW_W-1:0] upper,
  output logic [LOW_W-1:0]  beat
);
  localparam int UP_W = ADDR_W - LOW_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_low <= '0;
      upper    <= '0;
      beat     <= '0;
    end else if (load_ev) begin
      base_low <= start_addr[LOW_W-1:0];
      upper    <= start_addr[ADDR_W-1:LOW_W];
      beat     <= '0;
    end else if (step_ev) begin
      beat <= beat + 1'b1;
    end
  end

  p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (beat == '0) && ({upper, base_low} == $past(start_addr)));

  p_step_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> beat == LOW_W'($past(beat) + 1'b1));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ev && !step_ev) |=> $stable(beat) && $stable(base_low) && $stable(upper));

  p_upper_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ev |=> $stable(upper));

  logic [UP_W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
  parameter int LOW_W = 2
) (
  input  burst_pkg::order_e order,
  input  logic [LOW_W-1:0]  base_low,
  input  logic [LOW_W-1:0]  beat,
  output logic [LOW_W-1:0]  low_out
);
  function automatic logic [LOW_W-1:0] wrap_add(logic [LOW_W-1:0] a, logic [LOW_W-1:0] b);
    return a + b;
  endfunction

  logic [LOW_W-1:0] xor_low;
  logic [LOW_W-1:0] add_low;

  // interleaved order: each bit of the start flipped by the matching beat bit (R3)
  for (genvar i = 0; i < LOW_W; i++) begin : g_xbit
    assign xor_low[i] = base_low[i] ^ beat[i];
  end

  // linear order: modulo-2^LOW_W sum (R4)
  assign add_low = wrap_add(base_low, beat);

  assign low_out = (order == burst_pkg::ORD_INTERLEAVE) ? xor_low : add_low;
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr #(
  parameter int ADDR_W = 17,
  parameter int LOW_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              order_sel,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              adv_n,
  input  logic              strb_a_n,
  input  logic              strb_b_n,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [LOW_W-1:0]  beat_idx
);
  localparam int UP_W = ADDR_W - LOW_W;

  logic             load_ev;
  logic             step_ev;
  logic [LOW_W-1:0] base_low;
  logic [UP_W-1:0]  upper;
  logic [LOW_W-1:0] beat;
  logic [LOW_W-1:0] low_out;
  burst_pkg::order_e order;

  assign order = burst_pkg::order_e'(order_sel);

  burst_step_qual u_qual (
    .load     (load),
    .adv_n    (adv_n),
    .strb_a_n (strb_a_n),
    .strb_b_n (strb_b_n),
    .load_ev  (load_ev),
    .step_ev  (step_ev)
  );

  burst_beat_ctr #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_ev    (load_ev),
    .step_ev    (step_ev),
    .start_addr (start_addr),
    .base_low   (base_low),
    .upper      (upper),
    .beat       (beat)
  );

  burst_order_map #(.LOW_W(LOW_W)) u_map (
    .order    (order),
    .base_low (base_low),
    .beat     (beat),
    .low_out  (low_out)
  );

  assign burst_addr = {upper, low_out};
  assign beat_idx   = beat;

  // last beat plus a step returns to the starting low bits (R8)
  p_wrap_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && (&beat)) |=> (beat_idx == '0) && (burst_addr[LOW_W-1:0] == $past(base_low)));

  // a load on an advancing edge still restarts at beat 0 (R7)
  p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !adv_n && strb_a_n && strb_b_n) |=> beat_idx == '0);
endmodule

// File: tb/sim_burst_addr_ctr.sv
module sim_burst_addr_ctr;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          order_sel = 1'b1;
  logic          load = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          adv_n = 1'b1;
  logic          strb_a_n = 1'b1;
  logic          strb_b_n = 1'b1;
  logic [AW-1:0] burst_addr;
  logic [1:0]    beat_idx;

  int checks = 0;
  int fails  = 0;
  logic          done = 1'b0;

  always #10 clk = ~clk;

  burst_addr_ctr #(.ADDR_W(AW), .LOW_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .order_sel(order_sel), .load(load),
    .start_addr(start_addr), .adv_n(adv_n), .strb_a_n(strb_a_n),
    .strb_b_n(strb_b_n), .burst_addr(burst_addr), .beat_idx(beat_idx)
  );

  task automatic chk(string req, logic [AW-1:0] got, logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive one edge, then sample 1 ns after it
  task automatic edge1(logic ld, logic [AW-1:0] sa, logic av, logic a, logic b);
    load = ld; start_addr = sa; adv_n = av; strb_a_n = a; strb_b_n = b;
    @(posedge clk); #1;
    load = 1'b0; adv_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 addr", burst_addr, '0);
    chk("R1 beat", AW'(beat_idx), '0);
  endtask

  task automatic t_seq(string req, logic mode, logic [AW-1:0] sa,
                       logic [1:0] s1, logic [1:0] s2, logic [1:0] s3);
    order_sel = mode;
    edge1(1'b1, sa, 1'b0, 1'b1, 1'b1);
    chk({req, " R2 load"}, burst_addr, sa);
    chk("R2 beat", AW'(beat_idx), '0);
    edge1(1'b0, '0, 1'b0, 1'b1, 1'b1);
    chk({req, " b1"}, burst_addr, {sa[AW-1:2], s1});
    chk("R5 beat1", AW'(beat_idx), AW'(1));
    edge1(1'b0, '0, 1'b0, 1'b1, 1'b1);
    chk({req, " b2"}, burst_addr, {sa[AW-1:2], s2});
    edge1(1'b0, '0, 1'b0, 1'b1, 1'b1);
    chk({req, " b3"}, burst_addr, {sa[AW-1:2], s3});
    chk("R9 upper", AW'(burst_addr[AW-1:2]), AW'(sa[AW-1:2]));
    edge1(1'b0, '0, 1'b0, 1'b1, 1'b1);
    chk("R8 wrap addr", burst_addr, sa);
    chk("R8 wrap beat", AW'(beat_idx), '0);
  endtask

  task automatic t_suspend();
    logic [AW-1:0] sa = 17'h0F3A2;
    order_sel = 1'b0;
    edge1(1'b1, sa, 1'b1, 1'b1, 1'b1);
    edge1(1'b0, '0, 1'b0, 1'b1, 1'b1);
    chk("R4 lin b1", burst_addr, {sa[AW-1:2], 2'b11});
    edge1(1'b0, '0, 1'b1, 1'b1, 1'b1);
    chk("R6 adv high", burst_addr, {sa[AW-1:2], 2'b11});
    edge1(1'b0, '0, 1'b0, 1'b0, 1'b1);
    chk("R6 strb_a low", burst_addr, {sa[AW-1:2], 2'b11});
    edge1(1'b0, '0, 1'b0, 1'b1, 1'b0);
    chk("R6 strb_b low", AW'(beat_idx), AW'(1));
    edge1(1'b0, '0, 1'b0, 1'b1, 1'b1);
    chk("R5 resume", burst_addr, {sa[AW-1:2], 2'b00});
  endtask

  task automatic t_priority();
    logic [AW-1:0] sb = 17'h15557;
    order_sel = 1'b1;
    edge1(1'b1, sb, 1'b0, 1'b1, 1'b1);
    chk("R7 load vs adv addr", burst_addr, sb);
    chk("R7 load vs adv beat", AW'(beat_idx), '0);
    edge1(1'b0, '0, 1'b0, 1'b1, 1'b1);
    chk("R3 int b1 from 11", burst_addr, {sb[AW-1:2], 2'b10});
    edge1(1'b1, 17'h00008, 1'b0, 1'b1, 1'b1);
    chk("R7 reload mid burst", burst_addr, 17'h00008);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_seq("R3 int 01", 1'b1, 17'h0ABC5, 2'b00, 2'b11, 2'b10);
    t_seq("R3 int 10", 1'b1, 17'h12346, 2'b11, 2'b00, 2'b01);
    t_seq("R4 lin 01", 1'b0, 17'h0ABC5, 2'b10, 2'b11, 2'b00);
    t_seq("R4 lin 11", 1'b0, 17'h1FFFF, 2'b00, 2'b01, 2'b10);
    t_suspend();
    t_priority();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog got=hung exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule